// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external byte-wide asynchronous static RAM. The host raises a request carrying a write flag, an address and write data. The controller takes it when it is ready, then plays out the memory strobes. It uses active-low select, write enable and output enable, an address bus, and a data bus split into an output value, a drive enable and an input value. Each memory timing limit is met by holding a strobe phase for a whole number of clock cycles. A period parameter in picoseconds sets these cycle counts at elaboration time.

A write is the overlap of select and write enable. Both are pulled low together on one edge and raised together on a later edge. Output enable stays high during a write, and the write data is driven for one extra cycle after the strobes rise. A read pulls select and output enable low for the access time. The data bus is sampled on the edge that closes that window, and a one-cycle read-valid pulse returns the byte. After every read the controller waits out the memory's output float time before it can drive the bus again. The ready output is low for the full length of every access, so back-to-back requests cannot break the minimum cycle time.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever idle, select, write enable and output enable are high, the data drive enable is low and ready is high.
- R2: An accepted write holds select and write enable low together for NW = max(ceil(12000/P), ceil(8000/P), ceil(7000/P)) cycles, where P is the clock period in ps. Output enable stays high, and address and data stay stable. Select and write enable then rise on the same edge.
- R3: Write data is driven on every cycle in which write enable is low, and for exactly one cycle after the strobes rise.
- R4: An accepted read holds select and output enable low and write enable high for NR = ceil(15000/P) cycles. The input bus is sampled on the edge ending that window. The read-valid output is then high for exactly one cycle, in the cycle after that edge, with the sampled byte on the read-data output.
- R5: The data drivers are never enabled while output enable is low. After output enable rises, they stay disabled for at least NF = max(ceil(6000/P), ceil(5000/P)) cycles.
- R6: Ready is low from the edge that accepts a request until the access finishes. This lasts max(NW+1, ceil(15000/P)) cycles for a write and NR+NF cycles for a read.
- R7: A request presented while ready is low is ignored: it starts no access and leaves the memory contents unchanged.
- R8: Every wait count is the ceiling of its limit divided by the period parameter, and never less than one.
- R9: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse: read byte available |
| rd_data | output | DATA_W | Read byte |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | DATA_W | Data returned from memory |

## Verification
The hardest case to reach is the bus turnaround: a write issued on the first cycle that ready returns after a read. That is where the controller's drivers and the memory's still-floating outputs could overlap. The bench reaches it by pairing each write with an immediate read, and each read with an immediate next write, across every address of a 64-byte memory. Its behavioural memory counts the cycles since it stopped driving and flags any early drive. The memory returns junk until the access time has elapsed, so a capture that comes too soon produces a wrong byte. The ignored-request case is reached by pulsing a conflicting write in the middle of a busy cycle and reading that address back later.

// File: rtl/sram_async_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_async_ctrl_pkg;

    // memory timing limits in picoseconds
    localparam int LIM_WE_PULSE_PS  = 8000;
    localparam int LIM_DATA_SU_PS   = 7000;
    localparam int LIM_SEL_END_PS   = 12000;
    localparam int LIM_WCYCLE_PS    = 15000;
    localparam int LIM_ACCESS_PS    = 15000;
    localparam int LIM_RCYCLE_PS    = 15000;
    localparam int LIM_SEL_FLOAT_PS = 6000;
    localparam int LIM_OE_FLOAT_PS  = 5000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WHOLD,
        ST_READ,
        ST_REL
    } ctrl_state_e;

    // ceiling of limit over period, at least one cycle
    function automatic int wait_cycles(input int lim_ps, input int clk_ps);
        int r;
        r = (lim_ps + clk_ps - 1) / clk_ps;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_async_timer.sv
`timescale 1ns/1ps
module sram_async_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the current cycle is the final one of the loaded window
    assign last = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/sram_async_seq.sv
`timescale 1ns/1ps
module sram_async_seq
    import sram_async_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int N_WR   = 2,
    parameter int N_WH   = 1,
    parameter int N_RD   = 2,
    parameter int N_REL  = 1,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              rvalid;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr = req_addr;
                    s_d.cs_n = 1'b0;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        s_d.wdata = req_wdata;
                        s_d.we_n  = 1'b0;
                        s_d.drv   = 1'b1;
                        s_d.st    = ST_WRITE;
                        tmr_val   = CNT_W'(N_WR);
                    end else begin
                        s_d.oe_n  = 1'b0;
                        s_d.st    = ST_READ;
                        tmr_val   = CNT_W'(N_RD);
                    end
                end
            end
            ST_WRITE: begin
                if (tmr_last) begin
                    s_d.cs_n = 1'b1;
                    s_d.we_n = 1'b1;
                    s_d.st   = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_WH);
                end
            end
            ST_WHOLD: begin
                if (tmr_last) begin
                    s_d.drv = 1'b0;
                    s_d.st  = ST_IDLE;
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    s_d.rdata  = mem_dq_in;
                    s_d.rvalid = 1'b1;
                    s_d.cs_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                    s_d.st     = ST_REL;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(N_REL);
                end
            end
            ST_REL: begin
                if (tmr_last) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.cs_n   <= 1'b1;
            s_q.we_n   <= 1'b1;
            s_q.oe_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign mem_cs_n   = s_q.cs_n;
    assign mem_we_n   = s_q.we_n;
    assign mem_oe_n   = s_q.oe_n;
    assign mem_addr   = s_q.addr;
    assign mem_dq_out = s_q.wdata;
    assign mem_dq_oe  = s_q.drv;
    assign rd_valid   = s_q.rvalid;
    assign rd_data    = s_q.rdata;

    // ---------------- checking ----------------
    localparam int CHK_W   = CNT_W + 2;
    localparam int CHK_MAX = (1 << CHK_W) - 1;

    logic [CHK_W-1:0] we_low_cnt_q, oe_high_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt_q  <= '0;
            oe_high_cnt_q <= CHK_W'(CHK_MAX);
        end else begin
            we_low_cnt_q  <= mem_we_n ? '0 :
                             ((we_low_cnt_q == CHK_W'(CHK_MAX)) ? we_low_cnt_q : we_low_cnt_q + 1'b1);
            oe_high_cnt_q <= !mem_oe_n ? '0 :
                             ((oe_high_cnt_q == CHK_W'(CHK_MAX)) ? oe_high_cnt_q : oe_high_cnt_q + 1'b1);
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_write_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_cnt_q) >= N_WR));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_data_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    assert_release_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_high_cnt_q) >= N_REL));

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_async_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CLK_PS = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // R8: every window is a ceiling of limit / period, minimum one
    localparam int N_WR  = imax(wait_cycles(LIM_SEL_END_PS, CLK_PS),
                           imax(wait_cycles(LIM_WE_PULSE_PS, CLK_PS),
                                wait_cycles(LIM_DATA_SU_PS, CLK_PS)));
    localparam int N_WCY = wait_cycles(LIM_WCYCLE_PS, CLK_PS);
    localparam int N_WH  = imax(1, N_WCY - N_WR);
    localparam int N_RD  = imax(wait_cycles(LIM_ACCESS_PS, CLK_PS),
                                wait_cycles(LIM_RCYCLE_PS, CLK_PS));
    localparam int N_REL = imax(wait_cycles(LIM_SEL_FLOAT_PS, CLK_PS),
                                wait_cycles(LIM_OE_FLOAT_PS, CLK_PS));
    localparam int N_MAX = imax(imax(N_WR, N_WH), imax(N_RD, N_REL));
    localparam int CNT_W = $clog2(N_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;

    sram_async_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_async_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_WR   (N_WR),
        .N_WH   (N_WH),
        .N_RD   (N_RD),
        .N_REL  (N_REL),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .tmr_last   (tmr_last),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .mem_dq_in  (mem_dq_in),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    localparam int CLK_PERIOD_NS = 5;
    localparam int CLK_PS        = CLK_PERIOD_NS * 1000;
    localparam int AW            = 6;
    localparam int DW            = 8;
    localparam int DEPTH         = 1 << AW;
    localparam logic [5:0] IGN_ADDR = 6'd3;

    function automatic int cdiv(input int lim);
        int r;
        r = (lim + CLK_PS - 1) / CLK_PS;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WR   = mx(cdiv(12000), mx(cdiv(8000), cdiv(7000)));
    localparam int E_WBSY = mx(E_WR + 1, cdiv(15000));
    localparam int E_RD   = cdiv(15000);
    localparam int E_REL  = mx(cdiv(6000), cdiv(5000));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic          cs_n, we_n, oe_n, dq_oe;
    logic [AW-1:0] maddr;
    logic [DW-1:0] dq_out, dq_in;

    always #(CLK_PERIOD_NS / 2.0) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .CLK_PS (CLK_PS)
    ) i_sram_async_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_cs_n   (cs_n),
        .mem_we_n   (we_n),
        .mem_oe_n   (oe_n),
        .mem_addr   (maddr),
        .mem_dq_out (dq_out),
        .mem_dq_oe  (dq_oe),
        .mem_dq_in  (dq_in)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    function automatic logic [7:0] pat2(input int a);
        return 8'((a * 11 + 100) & 255);
    endfunction

    // ---------------- behavioural memory ----------------
    logic [DW-1:0] mem_m [DEPTH];
    int            wcnt = 0, rcnt = 0, rel_cnt = 1000, last_wcnt = 0;
    logic          w_prev = 1'b0;
    logic [AW-1:0] w_addr = '0;
    logic [DW-1:0] w_data = '0;
    wire           m_drive = !cs_n && we_n && !oe_n;

    assign dq_in = (m_drive && rcnt >= E_RD) ? mem_m[maddr] : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && !we_n) begin
                if (w_prev)
                    chk(maddr == w_addr && dq_out == w_data, "R2 addr/data stable",
                        {maddr, dq_out}, {w_addr, w_data});
                chk(dq_oe, "R3 data driven during write", dq_oe, 1);
                chk(oe_n, "R2 output enable high in write", oe_n, 1);
                wcnt++;
                w_addr = maddr;
                w_data = dq_out;
                w_prev = 1'b1;
            end else if (w_prev) begin
                chk(wcnt * CLK_PS >= 12000 && wcnt * CLK_PS >= 8000, "R2 write overlap length",
                    wcnt * CLK_PS, 12000);
                chk(cs_n && we_n, "R2 strobes rise together", {cs_n, we_n}, 3);
                chk(dq_oe, "R3 data hold cycle", dq_oe, 1);
                mem_m[w_addr] = w_data;
                last_wcnt = wcnt;
                wcnt = 0;
                w_prev = 1'b0;
            end
            rcnt    = m_drive ? rcnt + 1 : 0;
            rel_cnt = m_drive ? 0 : ((rel_cnt < 1000) ? rel_cnt + 1 : rel_cnt);
            if (dq_oe)
                chk(!m_drive && rel_cnt >= E_REL + 1, "R5 bus turnaround", rel_cnt, E_REL + 1);
        end
    end

    // ---------------- host tasks ----------------
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit inject, output int busy);
        int guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (inject && busy == 2) begin
                // R7: conflicting request while busy
                req_valid = 1'b1; req_write = 1'b1; req_addr = IGN_ADDR; req_wdata = 8'h55;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output int busy, output int lat);
        int guard = 0;
        int k = 1;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; lat = 0; d = 'x;
        while (!req_ready && busy < 100) begin
            busy++;
            if (rd_valid) begin lat = k; d = rd_data; end
            k++;
            @(negedge clk);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD_NS * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int busy, lat;
        logic [DW-1:0] d;

        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk(cs_n && we_n && oe_n, "R1 strobes high in reset", {cs_n, we_n, oe_n}, 7);
        chk(!dq_oe && !rd_valid, "R1 drivers off in reset", {dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(cs_n && we_n && oe_n && !dq_oe, "R1 idle quiet", {cs_n, we_n, oe_n, dq_oe}, 14);

        // sweep 1: fill every address
        for (int a = 0; a < DEPTH; a++) begin
            do_write(AW'(a), pat1(a), (a == 10), busy);
            chk(busy == E_WBSY, "R6 write busy length", busy, E_WBSY);
            chk(last_wcnt == E_WR, "R8 write window count", last_wcnt, E_WR);
        end
        chk(req_ready && cs_n && we_n && oe_n && !dq_oe, "R1 idle after writes",
            {req_ready, cs_n, we_n, oe_n, dq_oe}, 30);

        // sweep 2: read every address back
        for (int a = 0; a < DEPTH; a++) begin
            do_read(AW'(a), d, busy, lat);
            if (a == int'(IGN_ADDR))
                chk(d == pat1(a), "R7 ignored request left memory unchanged", d, pat1(a));
            else
                chk(d == pat1(a), "R9 read back", d, pat1(a));
            chk(busy == E_RD + E_REL, "R6 read busy length", busy, E_RD + E_REL);
            chk(lat == E_RD + 1, "R4 read valid timing", lat, E_RD + 1);
        end

        // sweep 3: alternating write then read, tight turnarounds
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_write(AW'(a), pat2(a), 1'b0, busy);
            do_read(AW'(a), d, busy, lat);
            chk(d == pat2(a), "R9 read after write", d, pat2(a));
            chk(lat == E_RD + 1, "R4 read valid timing", lat, E_RD + 1);
        end

        // neighbour check after sweep 3
        do_read(AW'(0), d, busy, lat);
        chk(d == pat2(0), "R9 final read", d, pat2(0));
        @(negedge clk);
        chk(!rd_valid, "R4 single-cycle valid", rd_valid, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule